// File: doc/BRIEF.md
# Consecutive-Cycle Over-Current Shutdown Guard

This block watches the current-limit flag that each phase's gate driver raises when a switching cycle is cut short by over-current. The flag arrives without regard to the local clock, so each phase's flag first passes through a two-flop synchronizer. It is then sampled once per switching period on a strobe. Each phase keeps its own count of back-to-back switching periods that had the flag raised. Any clean period resets that count. A single over-current event therefore never shuts the converter down. A sustained one does.

When any phase's run of limited periods goes past the programmed limit, the block disables both PWM outputs and records which phase or phases tripped. The response is chosen when the trip happens. In latch mode the outputs stay off until the clear input is pulsed. In hiccup mode the block waits a programmed number of switching periods. It then re-enables the outputs, clears the fault record and issues a one-cycle retry request.

Top module: `ocp_cycle_guard`

## Requirements
- R1: After reset, `pwm_disable_o` is 0, `phase_fault_o` is all zeros and `retry_req_o` is 0.
- R2: A limit flag is sampled through a two-flop synchronizer. A flag that rises in the same cycle as a strobe and falls in the next cycle is never counted.
- R3: On each strobe while running, a phase's count rises by one if its synchronized flag is 1, and returns to zero if the flag is 0. A clean strobe between two runs means the two runs are not added together.
- R4: A phase trips on the strobe at which its flag is 1 and its count already equals or exceeds `trip_limit_i`. This is the (limit+1)-th consecutive flagged strobe, so a limit of 0 trips on the first one. `pwm_disable_o` rises one clock after that strobe edge.
- R5: A trip on any phase disables both outputs with a single `pwm_disable_o`. Bit p of `phase_fault_o` is set only for each phase p that tripped on that strobe.
- R6: If `resp_hiccup_i` is 0 at the trip, the disable and the fault bits hold regardless of flags and strobes until `clear_i`.
- R7: If `resp_hiccup_i` is 1 at the trip, the block re-enables on the N-th strobe after the trip, where N is `hold_cycles_i` and a value of 0 counts as 1. At that point `pwm_disable_o` falls, the fault bits clear and `retry_req_o` pulses high for exactly one clock.
- R8: Counts are cleared on a trip and do not advance while disabled. After a retry, a further limit+1 consecutive flagged strobes are needed to trip again.
- R9: `clear_i` has priority over everything else. From any state it returns the block to running with counts and fault bits cleared on the next clock, and it does not raise `retry_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| limit_flag_i | input | NUM_PH (2) | Per-phase current-limit flag from the drivers, asynchronous |
| cyc_strobe_i | input | 1 | One-clock pulse per switching period |
| trip_limit_i | input | CNT_W (8) | Number of consecutive limited periods tolerated |
| resp_hiccup_i | input | 1 | 1: hiccup retry, 0: latch off |
| hold_cycles_i | input | HOLD_W (12) | Switching periods to wait in hiccup before re-enabling |
| clear_i | input | 1 | Clears faults and returns to running |
| pwm_disable_o | output | 1 | 1 forces all PWM outputs off |
| phase_fault_o | output | NUM_PH (2) | Phases that caused the present shutdown |
| retry_req_o | output | 1 | One-clock pulse when hiccup re-enables |

## Verification
The assertions take for granted that the strobe is a single-clock pulse and that `clear_i` is not held across the edges the properties watch. They also assume the limit, response and hold inputs only change while no strobe is pending. The bench drives strobes as isolated one-clock pulses four clocks apart. It changes configuration only between strobes, and it pulses clear for one clock. Flags are held stable for at least two clocks before the strobes meant to see them, except in the one case that deliberately tests synchronizer latency.

// File: rtl/ocp_guard_pkg.sv
package ocp_guard_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HOLD  = 2'd1,
    ST_LATCH = 2'd2
  } guard_st_e;
endpackage

// File: rtl/ocp_flag_sync.sv
module ocp_flag_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/ocp_phase_counter.sv
module ocp_phase_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             strobe_i,
  input  logic             flag_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             trip_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = clr_i | (run_i & strobe_i);
  assign trip_o = run_i & strobe_i & flag_i & (cnt_q >= limit_i);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (flag_i) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ocp_fault_ctrl.sv
module ocp_fault_ctrl
  import ocp_guard_pkg::*;
#(
  parameter int NUM_PH = 2,
  parameter int HOLD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PH-1:0] trip_i,
  input  logic              strobe_i,
  input  logic              hiccup_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic              clear_i,
  output logic              run_o,
  output logic              cnt_clr_o,
  output logic [NUM_PH-1:0] fault_o,
  output logic              retry_o
);
  localparam int HW1 = HOLD_W + 1;

  guard_st_e         st_q, st_d;
  logic [HOLD_W-1:0] hc_q, hc_d;
  logic [NUM_PH-1:0] fault_q, fault_d;
  logic              retry_q, retry_d;
  logic [HW1-1:0]    hold_eff;
  logic [HW1-1:0]    hc_next;
  logic              any_trip;

  assign any_trip = |trip_i;
  assign hold_eff = (hold_i == '0) ? HW1'(1) : {1'b0, hold_i};
  assign hc_next  = {1'b0, hc_q} + HW1'(1);

  always_comb begin
    st_d    = st_q;
    hc_d    = hc_q;
    fault_d = fault_q;
    retry_d = 1'b0;
    if (clear_i) begin
      st_d    = ST_RUN;
      hc_d    = '0;
      fault_d = '0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (any_trip) begin
            fault_d = trip_i;
            hc_d    = '0;
            st_d    = hiccup_i ? ST_HOLD : ST_LATCH;
          end
        end
        ST_HOLD: begin
          if (strobe_i) begin
            if (hc_next >= hold_eff) begin
              st_d    = ST_RUN;
              fault_d = '0;
              retry_d = 1'b1;
            end else begin
              hc_d = hc_next[HOLD_W-1:0];
            end
          end
        end
        ST_LATCH: begin
          st_d = ST_LATCH;
        end
        default: st_d = ST_LATCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      hc_q    <= '0;
      fault_q <= '0;
      retry_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      hc_q    <= hc_d;
      fault_q <= fault_d;
      retry_q <= retry_d;
    end
  end

  assign run_o     = (st_q == ST_RUN);
  assign cnt_clr_o = clear_i | any_trip;
  assign fault_o   = fault_q;
  assign retry_o   = retry_q;
endmodule

// File: rtl/ocp_cycle_guard.sv
module ocp_cycle_guard #(
  parameter int NUM_PH = 2,
  parameter int CNT_W  = 8,
  parameter int HOLD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PH-1:0] limit_flag_i,
  input  logic              cyc_strobe_i,
  input  logic [CNT_W-1:0]  trip_limit_i,
  input  logic              resp_hiccup_i,
  input  logic [HOLD_W-1:0] hold_cycles_i,
  input  logic              clear_i,
  output logic              pwm_disable_o,
  output logic [NUM_PH-1:0] phase_fault_o,
  output logic              retry_req_o
);
  logic [NUM_PH-1:0] flag_s;
  logic [NUM_PH-1:0] trip;
  logic              run;
  logic              cnt_clr;

  ocp_flag_sync #(.W(NUM_PH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (limit_flag_i),
    .sync_o  (flag_s)
  );

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    ocp_phase_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (run),
      .clr_i    (cnt_clr),
      .strobe_i (cyc_strobe_i),
      .flag_i   (flag_s[p]),
      .limit_i  (trip_limit_i),
      .trip_o   (trip[p])
    );
  end

  ocp_fault_ctrl #(.NUM_PH(NUM_PH), .HOLD_W(HOLD_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .trip_i    (trip),
    .strobe_i  (cyc_strobe_i),
    .hiccup_i  (resp_hiccup_i),
    .hold_i    (hold_cycles_i),
    .clear_i   (clear_i),
    .run_o     (run),
    .cnt_clr_o (cnt_clr),
    .fault_o   (phase_fault_o),
    .retry_o   (retry_req_o)
  );

  assign pwm_disable_o = ~run;
endmodule

// File: rtl/ocp_cycle_guard_chk.sv
module ocp_cycle_guard_chk #(
  parameter int NUM_PH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_strobe_i,
  input logic              clear_i,
  input logic              pwm_disable_o,
  input logic [NUM_PH-1:0] phase_fault_o,
  input logic              retry_req_o
);
  AST_DISABLE_ONLY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_disable_o) |-> $past(cyc_strobe_i)); // R4

  AST_FAULT_MEANS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (|phase_fault_o) |-> pwm_disable_o); // R5

  AST_OFF_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_disable_o |-> (|phase_fault_o)); // R5

  AST_RETRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req_o |=> !retry_req_o); // R7

  AST_RETRY_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req_o |-> (!pwm_disable_o && phase_fault_o == '0)); // R7

  AST_RETRY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req_o |-> $past(cyc_strobe_i)); // R7

  AST_CLEAR_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!pwm_disable_o && phase_fault_o == '0 && !retry_req_o)); // R9
endmodule

bind ocp_cycle_guard ocp_cycle_guard_chk #(.NUM_PH(NUM_PH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cyc_strobe_i  (cyc_strobe_i),
  .clear_i       (clear_i),
  .pwm_disable_o (pwm_disable_o),
  .phase_fault_o (phase_fault_o),
  .retry_req_o   (retry_req_o)
);

// File: tb/sim_ocp_cycle_guard.sv
`timescale 1ns/1ps
module sim_ocp_cycle_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  flag;
  logic        strobe;
  logic [7:0]  limit;
  logic        hiccup;
  logic [11:0] hold;
  logic        clear;
  logic        dis;
  logic [1:0]  fault;
  logic        retry;

  int errors = 0;
  int checks = 0;
  int retry_seen = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ocp_cycle_guard u0 (
    .clk(clk), .rst_n(rst_n), .limit_flag_i(flag), .cyc_strobe_i(strobe),
    .trip_limit_i(limit), .resp_hiccup_i(hiccup), .hold_cycles_i(hold),
    .clear_i(clear), .pwm_disable_o(dis), .phase_fault_o(fault),
    .retry_req_o(retry)
  );

  // behavioural reference: st 0 run, 1 waiting to retry, 2 latched
  logic [1:0] m_s1, m_s2, m_fault;
  int m_cnt [2];
  int m_st, m_hc;
  bit m_retry;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_fault = 0; m_st = 0; m_hc = 0; m_retry = 0;
      m_cnt[0] = 0; m_cnt[1] = 0;
    end else begin
      logic [1:0] fs, tr;
      bit nr;
      fs = m_s2; m_s2 = m_s1; m_s1 = flag;
      tr = 0; nr = 0;
      if (clear) begin
        m_st = 0; m_fault = 0; m_cnt[0] = 0; m_cnt[1] = 0;
      end else if (m_st == 0) begin
        if (strobe) begin
          for (int p = 0; p < 2; p++) begin
            if (fs[p]) begin
              if (m_cnt[p] >= int'(limit)) tr[p] = 1'b1;
              if (m_cnt[p] < 255) m_cnt[p]++;
            end else m_cnt[p] = 0;
          end
        end
        if (tr != 0) begin
          m_fault = tr; m_st = hiccup ? 1 : 2; m_hc = 0;
          m_cnt[0] = 0; m_cnt[1] = 0;
        end
      end else if (m_st == 1) begin
        if (strobe) begin
          if (m_hc + 1 >= ((hold == 0) ? 1 : int'(hold))) begin
            m_st = 0; m_fault = 0; nr = 1;
          end else m_hc++;
        end
      end
      m_retry = nr;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (dis !== (m_st != 0) || fault !== m_fault || retry !== m_retry) begin
        errors++;
        $display("FAIL model compare R3/R4/R5/R8 t=%0t: act dis=%b fault=%b retry=%b exp dis=%b fault=%b retry=%b",
                 $time, dis, fault, retry, (m_st != 0), m_fault, m_retry);
      end
      if (retry === 1'b1) retry_seen++;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobes(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) strobe = 1'b1;
      @(negedge clk) strobe = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic do_clear();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_flag(logic [1:0] f);
    @(negedge clk) flag = f;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int r0;
    rst_n = 0; flag = 0; strobe = 0; limit = 3; hiccup = 0; hold = 3; clear = 0;
    repeat (4) @(negedge clk);
    check("R1 disable after reset", dis, 0);
    check("R1 fault after reset", fault, 0);
    check("R1 retry after reset", retry, 0);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);

    // R3/R4/R5/R6: latch, phase 0, limit 3
    set_flag(2'b01);
    strobes(3);
    check("R3 three flagged strobes below limit", dis, 0);
    strobes(1);
    check("R4 fourth flagged strobe trips", dis, 1);
    check("R5 only phase0 fault bit", fault, 1);
    set_flag(2'b00);
    strobes(5);
    check("R6 latched stays off", dis, 1);
    check("R6 latched fault kept", fault, 1);
    do_clear();
    check("R9 clear re-enables", dis, 0);
    check("R9 clear drops fault", fault, 0);

    // R3: clean strobe breaks the run
    limit = 2;
    set_flag(2'b10);
    strobes(2);
    set_flag(2'b00);
    strobes(1);
    set_flag(2'b10);
    strobes(2);
    check("R3 broken run does not trip", dis, 0);
    strobes(1);
    check("R4 third consecutive trips", dis, 1);
    check("R5 only phase1 fault bit", fault, 2);
    set_flag(2'b00);
    do_clear();

    // R7/R8: hiccup with hold 3, flag kept high
    hiccup = 1; hold = 3; limit = 1;
    set_flag(2'b10);
    strobes(2);
    check("R7 hiccup trip disables", dis, 1);
    r0 = retry_seen;
    strobes(2);
    check("R7 still waiting after two", dis, 1);
    strobes(1);
    check("R7 re-enabled after hold", dis, 0);
    check("R7 fault cleared on retry", fault, 0);
    check("R7 one retry pulse", retry_seen - r0, 1);
    strobes(1);
    check("R8 fresh count after retry", dis, 0);
    strobes(1);
    check("R8 trips again after limit+1", dis, 1);

    // R9: clear during hold, no retry pulse
    r0 = retry_seen;
    do_clear();
    check("R9 clear aborts hold", dis, 0);
    check("R9 no retry from clear", retry_seen - r0, 0);
    set_flag(2'b00);

    // R5: both phases together; R7 hold 0 acts as 1
    hold = 0; limit = 0;
    set_flag(2'b11);
    strobes(1);
    check("R5 both phase fault bits", fault, 3);
    check("R4 limit zero trips on first", dis, 1);
    set_flag(2'b00);
    r0 = retry_seen;
    strobes(1);
    check("R7 hold zero retries after one", dis, 0);
    check("R7 hold zero retry pulse", retry_seen - r0, 1);

    // R2: flag too fresh at strobe is not seen
    hiccup = 0; limit = 0;
    repeat (3) @(negedge clk);
    @(negedge clk) begin flag = 2'b01; strobe = 1'b1; end
    @(negedge clk) begin flag = 2'b00; strobe = 1'b0; end
    repeat (6) @(negedge clk);
    check("R2 unsynchronized flag ignored", dis, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog R1: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule